// File: doc/BRIEF.md
# Multiplexed Address/Data Bus to Register Port Bridge

This block is a slave on a host bus whose 16 data lines carry first an address and then data, all timed by a burst clock that the host drives. Each transaction carries one 32-bit word. The host lowers chip select and the address-valid strobe together and places the address on the lines. The word then crosses as two 16-bit beats. For a write, the host drives both beats. For a read, the slave drives both beats back onto the lines through a tri-state enable.

On the inside, the block offers a plain register port: a word address, a write strobe with write data, a read strobe, read data and a ready input. A write goes to the register port only once both beats are held. A read request goes out as soon as the address phase ends. While the register side has not answered, the active-low wait output holds the host, so the host keeps clocking. A parameter chooses whether the lower or the upper half of the word travels first. The default is lower half first.

Top module: `mux_bus_bridge`

## Requirements
- R1: After reset, wait_n is 1, bus_doe is 0, reg_wr and reg_rd are 0, and reg_addr and reg_wdata are 0.
- R2: The address is taken from bus_din on the first rising clock edge at which both cs_n and adv_n are low. An edge with cs_n low and adv_n high starts nothing: no request follows and wait_n stays 1.
- R3: On a write (we_n low at the address edge), the lower 16 bits are taken on the next edge and the upper 16 bits on the edge after that. From the following cycle on, reg_wr is 1, reg_addr carries the address and reg_wdata carries {upper, lower}.
- R4: reg_wr stays 1 and wait_n stays 0 until an edge at which reg_ready is 1. From the next cycle on, reg_wr is 0 and wait_n is 1. With a responder latency of L idle cycles, wait_n is low for exactly L+1 cycles.
- R5: On a read (we_n high at the address edge), reg_rd is 1 from the cycle after the address edge. In that cycle reg_addr holds the address. wait_n is 0 for exactly as long as reg_rd is 1, and reg_rd stays 1 with a stable address until an edge at which reg_ready is 1.
- R6: After the edge that accepts reg_rdata, wait_n is 1. bus_dout carries the lower 16 bits for one cycle and then the upper 16 bits for one cycle.
- R7: bus_doe is 1 only while cs_n and oe_n are both low and one of the two read data cycles is in progress. When oe_n stays high, bus_doe stays 0 throughout the read.
- R8: cs_n high at any edge ends the transaction. In the next cycle reg_wr and reg_rd are 0, and reg_addr and reg_wdata read 0. A write cut short before its second beat never raises reg_wr and leaves the register contents unchanged.
- R9: After a completed transfer, the bridge holds wait_n at 1 and bus_doe at 0, issues no further request, and waits for cs_n to go high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock from the host; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select framing one transaction |
| adv_n | input | 1 | Active-low address-valid strobe |
| we_n | input | 1 | Active-low write direction, sampled at the address edge |
| oe_n | input | 1 | Active-low host output enable |
| bus_din | input | BUS_W | Value seen on the shared address/data lines |
| bus_dout | output | BUS_W | Value to place on the lines during a read data beat |
| bus_doe | output | 1 | Tri-state enable for bus_dout |
| wait_n | output | 1 | Active-low wait; low stretches the transfer |
| reg_addr | output | ADDR_W | Register port address |
| reg_wr | output | 1 | Register write request, held until ready |
| reg_wdata | output | WORD_W | Register write data |
| reg_rd | output | 1 | Register read request, held until ready |
| reg_rdata | input | WORD_W | Register read data, taken when reg_ready is 1 |
| reg_ready | input | 1 | Register port completion handshake |

## Verification
The address, the first beat and the second beat are each registered on their own edge, so reg_wr and reg_rd appear one cycle after the edge that completes their phase. wait_n, bus_doe and bus_dout are decoded from the state register without further delay. The bench changes inputs and samples outputs on the falling edge, one nanosecond after driving, so each check falls half a cycle after the edge that produced its result. It counts the falling edges that see wait_n low and compares the count with L+1 for the responder latency L. It then expects the lower read half in the first cycle that wait_n is high and the upper half in the cycle after.

// File: rtl/mux_bus_bridge_pkg.sv
package mux_bus_bridge_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WBEAT1 = 3'd1,
      ST_WBEAT2 = 3'd2,
      ST_WREQ  = 3'd3,
      ST_RREQ  = 3'd4,
      ST_RBEAT1 = 3'd5,
      ST_RBEAT2 = 3'd6,
      ST_DONE  = 3'd7
   } mbb_state_e;

   function automatic logic is_read_beat(input mbb_state_e s);
      return (s == ST_RBEAT1) || (s == ST_RBEAT2);
   endfunction

   function automatic logic is_stalled(input mbb_state_e s);
      return (s == ST_WREQ) || (s == ST_RREQ);
   endfunction

endpackage

// File: rtl/mbb_seq.sv
module mbb_seq
   import mux_bus_bridge_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       adv_n,
   input  logic       we_n,
   input  logic       reg_ready,
   output mbb_state_e state
);

   mbb_state_e state_nx;

   always_comb begin
      state_nx = state;
      if (cs_n) begin
         state_nx = ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE:   if (!adv_n) state_nx = we_n ? ST_RREQ : ST_WBEAT1;
            ST_WBEAT1: state_nx = ST_WBEAT2;
            ST_WBEAT2: state_nx = ST_WREQ;
            ST_WREQ:   if (reg_ready) state_nx = ST_DONE;
            ST_RREQ:   if (reg_ready) state_nx = ST_RBEAT1;
            ST_RBEAT1: state_nx = ST_RBEAT2;
            ST_RBEAT2: state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_DONE;
            default:   state_nx = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

endmodule

// File: rtl/mbb_capture.sv
module mbb_capture
   import mux_bus_bridge_pkg::*;
#(
   parameter int BUS_W    = 16,
   parameter int WORD_W   = 32,
   parameter int ADDR_W   = 16,
   parameter bit LO_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              adv_n,
   input  mbb_state_e        state,
   input  logic [BUS_W-1:0]  bus_din,
   input  logic              reg_ready,
   input  logic [WORD_W-1:0] reg_rdata,
   output logic [ADDR_W-1:0] addr_q,
   output logic [WORD_W-1:0] wword_q,
   output logic [WORD_W-1:0] rword_q
);

   localparam int FIRST_OFS  = LO_FIRST ? 0 : BUS_W;
   localparam int SECOND_OFS = BUS_W - FIRST_OFS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wword_q <= '0;
         rword_q <= '0;
      end else if (cs_n) begin
         addr_q  <= '0;
         wword_q <= '0;
         rword_q <= '0;
      end else begin
         if (state == ST_IDLE && !adv_n)
            addr_q <= bus_din[ADDR_W-1:0];
         if (state == ST_WBEAT1)
            wword_q[FIRST_OFS +: BUS_W] <= bus_din;
         if (state == ST_WBEAT2)
            wword_q[SECOND_OFS +: BUS_W] <= bus_din;
         if (state == ST_RREQ && reg_ready)
            rword_q <= reg_rdata;
      end
   end

endmodule

// File: rtl/mbb_drive.sv
module mbb_drive
   import mux_bus_bridge_pkg::*;
#(
   parameter int BUS_W    = 16,
   parameter int WORD_W   = 32,
   parameter bit LO_FIRST = 1'b1
) (
   input  logic              cs_n,
   input  logic              oe_n,
   input  mbb_state_e        state,
   input  logic [WORD_W-1:0] rword_q,
   output logic [BUS_W-1:0]  bus_dout,
   output logic              bus_doe
);

   logic [BUS_W-1:0] beat_first;
   logic [BUS_W-1:0] beat_second;

   generate
      if (LO_FIRST) begin : g_lo_first
         assign beat_first  = rword_q[BUS_W-1:0];
         assign beat_second = rword_q[WORD_W-1:BUS_W];
      end else begin : g_hi_first
         assign beat_first  = rword_q[WORD_W-1:BUS_W];
         assign beat_second = rword_q[BUS_W-1:0];
      end
   endgenerate

   assign bus_dout = (state == ST_RBEAT2) ? beat_second : beat_first;
   assign bus_doe  = !cs_n && !oe_n && is_read_beat(state);

endmodule

// File: rtl/mux_bus_bridge.sv
module mux_bus_bridge
   import mux_bus_bridge_pkg::*;
#(
   parameter int BUS_W    = 16,
   parameter int WORD_W   = 32,
   parameter int ADDR_W   = 16,
   parameter bit LO_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              adv_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [BUS_W-1:0]  bus_din,
   output logic [BUS_W-1:0]  bus_dout,
   output logic              bus_doe,
   output logic              wait_n,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_wr,
   output logic [WORD_W-1:0] reg_wdata,
   output logic              reg_rd,
   input  logic [WORD_W-1:0] reg_rdata,
   input  logic              reg_ready
);

   generate
      if (BUS_W < 1) begin : g_bad_bus
         $error("mux_bus_bridge: BUS_W must be at least 1");
      end
      if (WORD_W != 2 * BUS_W) begin : g_bad_word
         $error("mux_bus_bridge: WORD_W must equal two beats of BUS_W");
      end
      if (ADDR_W < 1 || ADDR_W > BUS_W) begin : g_bad_addr
         $error("mux_bus_bridge: ADDR_W must fit on the bus lines");
      end
   endgenerate

   mbb_state_e        state;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] wword_q;
   logic [WORD_W-1:0] rword_q;

   mbb_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .adv_n     (adv_n),
      .we_n      (we_n),
      .reg_ready (reg_ready),
      .state     (state)
   );

   mbb_capture #(
      .BUS_W    (BUS_W),
      .WORD_W   (WORD_W),
      .ADDR_W   (ADDR_W),
      .LO_FIRST (LO_FIRST)
   ) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .adv_n     (adv_n),
      .state     (state),
      .bus_din   (bus_din),
      .reg_ready (reg_ready),
      .reg_rdata (reg_rdata),
      .addr_q    (addr_q),
      .wword_q   (wword_q),
      .rword_q   (rword_q)
   );

   mbb_drive #(
      .BUS_W    (BUS_W),
      .WORD_W   (WORD_W),
      .LO_FIRST (LO_FIRST)
   ) u_drive (
      .cs_n     (cs_n),
      .oe_n     (oe_n),
      .state    (state),
      .rword_q  (rword_q),
      .bus_dout (bus_dout),
      .bus_doe  (bus_doe)
   );

   assign reg_addr  = addr_q;
   assign reg_wdata = wword_q;
   assign reg_wr    = (state == ST_WREQ);
   assign reg_rd    = (state == ST_RREQ);
   assign wait_n    = !is_stalled(state);

endmodule

// File: rtl/mux_bus_bridge_chk.sv
module mux_bus_bridge_chk #(
   parameter int BUS_W  = 16,
   parameter int WORD_W = 32,
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              oe_n,
   input logic              bus_doe,
   input logic              wait_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic              reg_ready
);

   // R4
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_ready && !cs_n) |=> reg_wr);

   // R4
   wr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> !wait_n);

   // R5
   rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |-> !wait_n);

   // R5
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !reg_ready && !cs_n) |=> (reg_rd && $stable(reg_addr)));

   // R7
   doe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_doe |-> (!cs_n && !oe_n));

   // R8
   cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (!reg_wr && !reg_rd && !bus_doe));

   // R8
   cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (reg_addr == '0));

endmodule

bind mux_bus_bridge mux_bus_bridge_chk #(
   .BUS_W  (BUS_W),
   .WORD_W (WORD_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .oe_n      (oe_n),
   .bus_doe   (bus_doe),
   .wait_n    (wait_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_ready (reg_ready)
);

// File: tb/mux_bus_bridge_tb.sv
`timescale 1ns / 1ps
module mux_bus_bridge_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        adv_n = 1'b1;
   logic        we_n = 1'b1;
   logic        oe_n = 1'b1;
   logic [15:0] bus_din = '0;
   logic [15:0] bus_dout;
   logic        bus_doe;
   logic        wait_n;
   logic [15:0] reg_addr;
   logic        reg_wr;
   logic [31:0] reg_wdata;
   logic        reg_rd;
   logic [31:0] reg_rdata = '0;
   logic        reg_ready = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;
   int lat     = 0;
   int cnt     = 0;
   int n_wr    = 0;
   logic [31:0] mem [16];

   always #2.5 clk = ~clk;

   mux_bus_bridge u_dut (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .adv_n (adv_n),
      .we_n (we_n), .oe_n (oe_n), .bus_din (bus_din),
      .bus_dout (bus_dout), .bus_doe (bus_doe), .wait_n (wait_n),
      .reg_addr (reg_addr), .reg_wr (reg_wr), .reg_wdata (reg_wdata),
      .reg_rd (reg_rd), .reg_rdata (reg_rdata), .reg_ready (reg_ready)
   );

   // register-side responder: answers after lat idle cycles
   always @(negedge clk) begin
      if (!rst_n) begin
         reg_ready <= 1'b0;
         cnt = 0;
      end else if (reg_ready) begin
         reg_ready <= 1'b0;
         cnt = 0;
      end else if (reg_wr || reg_rd) begin
         if (cnt >= lat) begin
            reg_ready <= 1'b1;
            if (reg_wr) begin
               mem[reg_addr[3:0]] = reg_wdata;
               n_wr++;
            end else begin
               reg_rdata <= mem[reg_addr[3:0]];
            end
         end else begin
            cnt++;
         end
      end else begin
         cnt = 0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic count_wait(output int n);
      n = 0;
      while (wait_n == 1'b0 && n < 60) begin
         n++;
         step();
      end
   endtask

   task automatic end_txn();
      @(negedge clk);
      cs_n = 1'b1; oe_n = 1'b1; adv_n = 1'b1; we_n = 1'b1;
      step();
      chk("R8 addr cleared", {16'h0, reg_addr}, 32'h0);
      chk("R8 wdata cleared", reg_wdata, 32'h0);
   endtask

   task automatic test_reset();
      chk("R1 wait_n", {31'h0, wait_n}, 32'h1);
      chk("R1 bus_doe", {31'h0, bus_doe}, 32'h0);
      chk("R1 requests", {30'h0, reg_wr, reg_rd}, 32'h0);
      chk("R1 addr/wdata", {16'h0, reg_addr} | reg_wdata, 32'h0);
   endtask

   task automatic do_write(input logic [15:0] a, input logic [31:0] d, input int l);
      int n;
      int wr0;
      wr0 = n_wr;
      lat = l;
      @(negedge clk);
      cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b0; bus_din = a;
      @(negedge clk);
      adv_n = 1'b1; bus_din = d[15:0];
      #1;
      chk("R3 no early write", {31'h0, reg_wr}, 32'h0);
      chk("R2 wait_n high in address phase", {31'h0, wait_n}, 32'h1);
      @(negedge clk);
      bus_din = d[31:16];
      step();
      chk("R3 reg_wr raised", {31'h0, reg_wr}, 32'h1);
      chk("R2 captured address", {16'h0, reg_addr}, {16'h0, a});
      chk("R3 write word", reg_wdata, d);
      count_wait(n);
      chk("R4 wait cycles", n, l + 1);
      chk("R4 reg_wr dropped", {31'h0, reg_wr}, 32'h0);
      chk("R4 one write issued", n_wr - wr0, 1);
      step();
      chk("R9 idle after done", {29'h0, wait_n, bus_doe, reg_wr}, 32'h4);
      end_txn();
   endtask

   task automatic do_read(input logic [15:0] a, input logic [31:0] exp, input int l,
                          input logic use_oe);
      int n;
      lat = l;
      @(negedge clk);
      cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; bus_din = a;
      @(negedge clk);
      adv_n = 1'b1; oe_n = !use_oe; bus_din = '0;
      #1;
      chk("R5 reg_rd raised", {31'h0, reg_rd}, 32'h1);
      chk("R5 read address", {16'h0, reg_addr}, {16'h0, a});
      chk("R7 no drive while waiting", {31'h0, bus_doe}, 32'h0);
      count_wait(n);
      chk("R5 wait cycles", n, l + 1);
      chk("R6 lower half", {16'h0, bus_dout}, {16'h0, exp[15:0]});
      chk("R7 drive first beat", {31'h0, bus_doe}, {31'h0, use_oe});
      step();
      chk("R6 upper half", {16'h0, bus_dout}, {16'h0, exp[31:16]});
      chk("R7 drive second beat", {31'h0, bus_doe}, {31'h0, use_oe});
      chk("R6 wait_n high", {31'h0, wait_n}, 32'h1);
      step();
      chk("R9 released after read", {30'h0, bus_doe, reg_rd}, 32'h0);
      end_txn();
   endtask

   task automatic test_abort(input logic [15:0] a, input logic [31:0] d);
      int wr0;
      wr0 = n_wr;
      @(negedge clk);
      cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b0; bus_din = a;
      @(negedge clk);
      adv_n = 1'b1; bus_din = d[15:0];
      @(negedge clk);
      cs_n = 1'b1; we_n = 1'b1; bus_din = d[31:16];
      step();
      chk("R8 no write after abort", {31'h0, reg_wr}, 32'h0);
      chk("R8 addr cleared on abort", {16'h0, reg_addr}, 32'h0);
      chk("R8 wdata cleared on abort", reg_wdata, 32'h0);
      repeat (4) step();
      chk("R8 write count unchanged", n_wr - wr0, 0);
   endtask

   task automatic test_adv_high();
      @(negedge clk);
      cs_n = 1'b0; adv_n = 1'b1; we_n = 1'b1; bus_din = 16'h0007;
      step();
      step();
      chk("R2 no request without adv_n", {30'h0, reg_rd, reg_wr}, 32'h0);
      chk("R2 wait_n stays high", {31'h0, wait_n}, 32'h1);
      end_txn();
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      #1;
      test_reset();
      rst_n = 1'b1;
      do_write(16'h0003, 32'hAA55A5A5, 0);
      do_write(16'h0005, 32'h11221212, 3);
      do_read(16'h0003, 32'hAA55A5A5, 0, 1'b1);
      do_read(16'h0005, 32'h11221212, 2, 1'b1);
      do_read(16'h0003, 32'hAA55A5A5, 1, 1'b0);
      test_abort(16'h0003, 32'hDEADBEEF);
      do_read(16'h0003, 32'hAA55A5A5, 0, 1'b1);
      test_adv_high();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #100000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule